// File: doc/BRIEF.md
# Ring Buffer Command Parser

This block drains a circular command stream kept in a small word-addressed shared memory. The first four words of that memory form a header of byte offsets: word 0 is the lower bound of the ring, word 1 its upper bound, word 2 the producer's write offset and word 3 the consumer's read offset. A producer appends 32-bit command words between the two bounds and then advances word 2. The block reads commands at word 3, decodes them, and advances word 3 by writing it back once each command has been fully consumed.

Three drawing commands are decoded and presented on a valid/ready output with their argument words: an update-rectangle, a fill-rectangle and a copy-rectangle. Known commands the block does not draw are stepped over by their full length, so the stream stays aligned. A command whose words have not all arrived is left in place: the read offset keeps pointing at its opcode, and parsing resumes once the producer publishes more words. Software commits the header with a pulse that validates it. A sync pulse raises a busy flag that drops once the ring has been drained as far as possible.

Top module: `cmdring_parser`

## Requirements
- R1: After reset, `cmd_valid_o`, `busy_o`, `configured_o`, `unknown_o` and `mem_we_o` are all 0.
- R2: A commit pulse reads header words 0..3 and sets `configured_o` only if all four offsets are multiples of 4, the lower bound is at least 16, the upper bound is at most 0x10000 and the upper bound is at least the lower bound plus 10240; otherwise `configured_o` is 0 after the commit.
- R3: Opcodes 1 and 25 are 5-word update commands; each is presented with `cmd_kind_o` = 0 and x, y, w, h in argument slots 0..3 (slot i at `cmd_args_o[32*i +: 32]`, unused slots 0).
- R4: Opcode 2 is a 6-word fill; it is presented with `cmd_kind_o` = 1 and colour, x, y, w, h in slots 0..4.
- R5: Opcode 3 is a 7-word copy; it is presented with `cmd_kind_o` = 2 and source x, source y, destination x, destination y, w, h in slots 0..5.
- R6: While `cmd_valid_o` is high and `cmd_ready_i` is low, the kind and arguments hold and the read offset in word 3 is not written; the read offset moves past the command only on acceptance.
- R7: If fewer words are available than the command at the read offset needs, nothing is presented and word 3 is left unchanged; the command is parsed once the producer publishes its remaining words.
- R8: Opcodes 13, 14 and 28 are consumed together with 6, 7 and 12 following words respectively and produce no output.
- R9: Opcodes 0, 26, 27, 29 and 30 are consumed as single words with no output; any other opcode not listed in R3, R4, R5 or R8 is consumed as a single word and pulses `unknown_o` for one cycle.
- R10: Every read that steps to or beyond the upper bound continues at the lower bound, so a command may straddle the end of the ring.
- R11: A sync pulse sets `busy_o` on the next cycle; it stays high while a command waits for acceptance and clears once no complete command remains.
- R12: While `enable_i` is low nothing is parsed and `configured_o` is 0, and a sync pulse clears again without any parsing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Device enable; low stops parsing and clears the configured flag |
| commit_i | input | 1 | Pulse: validate the header and set the configured flag |
| sync_i | input | 1 | Pulse: request a drain, sets busy |
| mem_raddr_o | output | MEM_AW | Word address of the shared-memory read port (data one cycle later) |
| mem_rdata_i | input | 32 | Read data for the address given in the previous cycle |
| mem_we_o | output | 1 | Write strobe for header word 3 (read offset) |
| mem_wdata_o | output | 32 | New read offset written to word 3 |
| cmd_valid_o | output | 1 | Decoded drawing command is valid |
| cmd_ready_i | input | 1 | Consumer accepts the command |
| cmd_kind_o | output | 2 | 0 update, 1 fill, 2 copy |
| cmd_args_o | output | 32*MAX_ARGS | Argument words, slot i at bits 32*i+31..32*i |
| unknown_o | output | 1 | One-cycle pulse when an unrecognised opcode is dropped |
| configured_o | output | 1 | Header accepted and device enabled |
| busy_o | output | 1 | Sync in progress |

## Verification
The stream is driven with back-to-back update, fill and copy commands, with a command stalled behind a low ready, with a copy published in two halves, and with a mix of skipped, no-op and unrecognised opcodes ahead of a real command; comparing each accepted output and the written-back read offset against a queue model separates wrong argument order, wrong skip lengths and a premature pointer update. A separate header places the read offset eight bytes before the upper bound so a copy straddles the end, which exposes a missing or misplaced wrap. Header commits are tried with one fault each (misaligned offset, lower bound too small, upper bound too large, span too short) and with the exact upper limit, which distinguishes each validation clause from an off-by-one.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        K_UPDATE = 2'd0,
        K_FILL   = 2'd1,
        K_COPY   = 2'd2
    } cmd_kind_e;

    // Decoded opcode properties: total words, whether it is presented, kind, unknown flag
    typedef struct packed {
        logic [4:0] words;
        logic       emit;
        cmd_kind_e  kind;
        logic       unknown;
    } op_info_t;

    // Step a byte offset forward by n words, wrapping at the upper bound
    function automatic logic [WORD_W-1:0] ring_adv(
        input logic [WORD_W-1:0] ptr,
        input logic [4:0]        n,
        input logic [WORD_W-1:0] lo,
        input logic [WORD_W-1:0] hi
    );
        logic [WORD_W-1:0] s;
        s = ptr + {25'd0, n, 2'b00};
        if (s >= hi) s = s - hi + lo;
        return s;
    endfunction

    // Words between read and write offsets, accounting for wrap
    function automatic logic [WORD_W-1:0] ring_fill(
        input logic [WORD_W-1:0] wr,
        input logic [WORD_W-1:0] rd,
        input logic [WORD_W-1:0] lo,
        input logic [WORD_W-1:0] hi
    );
        logic [WORD_W:0] d;
        d = {1'b0, wr} - {1'b0, rd};
        if (d[WORD_W]) d = d + {1'b0, hi} - {1'b0, lo};
        return {2'b00, d[WORD_W-1:2]};
    endfunction

endpackage

// File: rtl/cring_cfg_check.sv
module cring_cfg_check
    import cmdring_pkg::*;
#(
    parameter logic [31:0] LIMIT_BYTES = 32'h0001_0000,
    parameter logic [31:0] MIN_SPAN    = 32'd10240,
    parameter logic [31:0] HDR_BYTES   = 32'd16
) (
    input  logic [WORD_W-1:0] lo_i,
    input  logic [WORD_W-1:0] hi_i,
    input  logic [WORD_W-1:0] wr_i,
    input  logic [WORD_W-1:0] rd_i,
    output logic              ok_o
);
    logic aligned, lo_ok, hi_ok, span_ok;

    always_comb begin
        aligned = ((lo_i | hi_i | wr_i | rd_i) & 32'd3) == 32'd0;
        lo_ok   = lo_i >= HDR_BYTES;
        hi_ok   = hi_i <= LIMIT_BYTES;
        span_ok = {1'b0, hi_i} >= ({1'b0, lo_i} + {1'b0, MIN_SPAN});
        ok_o    = aligned && lo_ok && hi_ok && span_ok;
    end
endmodule

// File: rtl/cring_op_decode.sv
module cring_op_decode
    import cmdring_pkg::*;
(
    input  logic [WORD_W-1:0] op_i,
    output op_info_t          info_o
);
    always_comb begin
        info_o = '{words: 5'd1, emit: 1'b0, kind: K_UPDATE, unknown: 1'b0};
        case (op_i)
            32'd1, 32'd25: info_o = '{words: 5'd5,  emit: 1'b1, kind: K_UPDATE, unknown: 1'b0};
            32'd2:         info_o = '{words: 5'd6,  emit: 1'b1, kind: K_FILL,   unknown: 1'b0};
            32'd3:         info_o = '{words: 5'd7,  emit: 1'b1, kind: K_COPY,   unknown: 1'b0};
            32'd13:        info_o.words = 5'd7;
            32'd14:        info_o.words = 5'd8;
            32'd28:        info_o.words = 5'd13;
            32'd0, 32'd26, 32'd27, 32'd29, 32'd30: info_o.words = 5'd1;
            default:       info_o.unknown = 1'b1;
        endcase
    end
endmodule

// File: rtl/cring_arg_bank.sv
module cring_arg_bank
    import cmdring_pkg::*;
#(
    parameter int N_SLOTS = 6,
    localparam int IDX_W  = $clog2(N_SLOTS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clr_i,
    input  logic                      cap_i,
    input  logic [IDX_W-1:0]          idx_i,
    input  logic [WORD_W-1:0]         data_i,
    output logic [N_SLOTS*WORD_W-1:0] args_o
);
    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        logic [WORD_W-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (rst || clr_i)                       slot_q <= '0;
            else if (cap_i && idx_i == IDX_W'(g))   slot_q <= data_i;
        end
        assign args_o[g*WORD_W +: WORD_W] = slot_q;
    end
endmodule

// File: rtl/cmdring_parser.sv
module cmdring_parser
    import cmdring_pkg::*;
#(
    parameter int          MEM_AW      = 14,
    parameter int          MAX_ARGS    = 6,
    parameter logic [31:0] LIMIT_BYTES = 32'h0001_0000,
    parameter logic [31:0] MIN_SPAN    = 32'd10240,
    parameter logic [31:0] HDR_BYTES   = 32'd16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       enable_i,
    input  logic                       commit_i,
    input  logic                       sync_i,
    output logic [MEM_AW-1:0]          mem_raddr_o,
    input  logic [31:0]                mem_rdata_i,
    output logic                       mem_we_o,
    output logic [31:0]                mem_wdata_o,
    output logic                       cmd_valid_o,
    input  logic                       cmd_ready_i,
    output logic [1:0]                 cmd_kind_o,
    output logic [MAX_ARGS*32-1:0]     cmd_args_o,
    output logic                       unknown_o,
    output logic                       configured_o,
    output logic                       busy_o
);
    localparam int IDX_W = $clog2(MAX_ARGS);

    typedef enum logic [3:0] {
        S_IDLE, S_CFG_A, S_CFG_LO, S_CFG_HI, S_CFG_WR, S_CFG_RD,
        S_PTR_A, S_PTR_WR, S_PTR_RD, S_OP, S_ARG, S_OUT
    } st_e;

    st_e               state;
    logic [WORD_W-1:0] ring_lo, ring_hi, wr_q, rd_q, cur, avail_q;
    logic [IDX_W-1:0]  arg_idx, arg_last;
    cmd_kind_e         kind_q;
    logic              commit_pend, cfg_ok, drained, run;
    logic [WORD_W-1:0] avail_now;
    op_info_t          info;

    cring_cfg_check #(.LIMIT_BYTES(LIMIT_BYTES), .MIN_SPAN(MIN_SPAN), .HDR_BYTES(HDR_BYTES))
        u_cfg (.lo_i(ring_lo), .hi_i(ring_hi), .wr_i(wr_q), .rd_i(mem_rdata_i), .ok_o(cfg_ok));

    cring_op_decode u_dec (.op_i(mem_rdata_i), .info_o(info));

    cring_arg_bank #(.N_SLOTS(MAX_ARGS)) u_args (
        .clk(clk), .rst(rst),
        .clr_i(state == S_OP && !drained && info.emit),
        .cap_i(state == S_ARG), .idx_i(arg_idx), .data_i(mem_rdata_i),
        .args_o(cmd_args_o));

    assign run       = enable_i && configured_o;
    assign avail_now = ring_fill(wr_q, mem_rdata_i, ring_lo, ring_hi);

    always_comb begin
        mem_raddr_o = '0;
        mem_we_o    = 1'b0;
        mem_wdata_o = cur;
        unknown_o   = 1'b0;
        drained     = 1'b0;
        case (state)
            S_CFG_A:  mem_raddr_o = MEM_AW'(0);
            S_CFG_LO: mem_raddr_o = MEM_AW'(1);
            S_CFG_HI: mem_raddr_o = MEM_AW'(2);
            S_CFG_WR: mem_raddr_o = MEM_AW'(3);
            S_PTR_A:  mem_raddr_o = MEM_AW'(2);
            S_PTR_WR: mem_raddr_o = MEM_AW'(3);
            S_PTR_RD: begin
                mem_raddr_o = MEM_AW'(mem_rdata_i >> 2);
                drained     = avail_now == '0;
            end
            S_OP: begin
                mem_raddr_o = MEM_AW'(cur >> 2);
                if (avail_q < {27'd0, info.words}) begin
                    drained = 1'b1;            // rewind: read offset untouched
                end else if (!info.emit) begin
                    mem_we_o    = 1'b1;
                    mem_wdata_o = ring_adv(rd_q, info.words, ring_lo, ring_hi);
                    unknown_o   = info.unknown;
                end
            end
            S_ARG:    mem_raddr_o = MEM_AW'(cur >> 2);
            S_OUT:    mem_we_o = cmd_ready_i;
            default:  ;
        endcase
    end

    assign cmd_valid_o = state == S_OUT;
    assign cmd_kind_o  = kind_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= S_IDLE;
            ring_lo      <= '0;
            ring_hi      <= '0;
            wr_q         <= '0;
            rd_q         <= '0;
            cur          <= '0;
            avail_q      <= '0;
            arg_idx      <= '0;
            arg_last     <= '0;
            kind_q       <= K_UPDATE;
            commit_pend  <= 1'b0;
            configured_o <= 1'b0;
            busy_o       <= 1'b0;
        end else begin
            if (state == S_CFG_A) commit_pend <= commit_i;
            else if (commit_i)    commit_pend <= 1'b1;

            if (!enable_i)             configured_o <= 1'b0;
            else if (state == S_CFG_RD) configured_o <= cfg_ok;

            if (sync_i) busy_o <= 1'b1;
            else if (drained || (state == S_IDLE && !run && !commit_pend)) busy_o <= 1'b0;

            case (state)
                S_IDLE: begin
                    if (commit_pend) state <= S_CFG_A;
                    else if (run)    state <= S_PTR_A;
                end
                S_CFG_A:  state <= S_CFG_LO;
                S_CFG_LO: begin ring_lo <= mem_rdata_i; state <= S_CFG_HI; end
                S_CFG_HI: begin ring_hi <= mem_rdata_i; state <= S_CFG_WR; end
                S_CFG_WR: begin wr_q    <= mem_rdata_i; state <= S_CFG_RD; end
                S_CFG_RD: state <= S_IDLE;
                S_PTR_A:  state <= S_PTR_WR;
                S_PTR_WR: begin wr_q <= mem_rdata_i; state <= S_PTR_RD; end
                S_PTR_RD: begin
                    rd_q    <= mem_rdata_i;
                    avail_q <= avail_now;
                    cur     <= ring_adv(mem_rdata_i, 5'd1, ring_lo, ring_hi);
                    state   <= drained ? S_IDLE : S_OP;
                end
                S_OP: begin
                    if (!drained && info.emit) begin
                        kind_q   <= info.kind;
                        arg_idx  <= '0;
                        arg_last <= IDX_W'(info.words - 5'd2);
                        cur      <= ring_adv(cur, 5'd1, ring_lo, ring_hi);
                        state    <= S_ARG;
                    end else begin
                        state <= S_IDLE;
                    end
                end
                S_ARG: begin
                    if (arg_idx == arg_last) begin
                        state <= S_OUT;
                    end else begin
                        arg_idx <= arg_idx + 1'b1;
                        cur     <= ring_adv(cur, 5'd1, ring_lo, ring_hi);
                    end
                end
                S_OUT:   if (cmd_ready_i) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // R6: a stalled command keeps its contents
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_args_o) && $stable(cmd_kind_o));

    // R6: the read offset is not written back while the command waits
    p_nowrite_stall_r6: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o && !cmd_ready_i |-> !mem_we_o);

    // R11: sync raises busy on the following cycle
    p_sync_busy_r11: assert property (@(posedge clk) disable iff (rst)
        sync_i |=> busy_o);

    // R12: disabling drops the configured flag
    p_disable_r12: assert property (@(posedge clk) disable iff (rst)
        !enable_i |=> !configured_o);

    // R10: a written-back read offset is aligned and inside the ring
    p_wb_range_r10: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> (mem_wdata_o[1:0] == 2'b00) && mem_wdata_o >= ring_lo && mem_wdata_o < ring_hi);

    // R9: an unknown opcode is consumed, so the read offset is written back
    p_unknown_consumed_r9: assert property (@(posedge clk) disable iff (rst)
        unknown_o |-> mem_we_o && !cmd_valid_o);
endmodule

// File: tb/cmdring_parser_test.sv
`timescale 1ns/1ps
module cmdring_parser_test;
    logic         clk = 1'b0;
    logic         rst, enable, commit, sync, ready;
    logic [13:0]  mem_raddr;
    logic [31:0]  mem_rdata;
    logic         mem_we;
    logic [31:0]  mem_wdata;
    logic         cmd_valid, unknown, configured, busy;
    logic [1:0]   cmd_kind;
    logic [191:0] cmd_args;

    logic [31:0]  mem [0:4095];
    logic         tb_we;
    logic [11:0]  tb_addr;
    logic [31:0]  tb_data;

    int checks = 0, fails = 0, cyc = 0, out_cnt = 0, unk_cnt = 0;
    bit done = 0;
    int wp, rmin, rmax;
    int           exp_kind[$];
    logic [191:0] exp_args[$];
    string        exp_req[$];
    bit           prev_stall = 0;
    logic [191:0] prev_args;
    logic [1:0]   prev_kind;

    always #2 clk = ~clk;

    cmdring_parser uut (
        .clk(clk), .rst(rst), .enable_i(enable), .commit_i(commit), .sync_i(sync),
        .mem_raddr_o(mem_raddr), .mem_rdata_i(mem_rdata), .mem_we_o(mem_we),
        .mem_wdata_o(mem_wdata), .cmd_valid_o(cmd_valid), .cmd_ready_i(ready),
        .cmd_kind_o(cmd_kind), .cmd_args_o(cmd_args), .unknown_o(unknown),
        .configured_o(configured), .busy_o(busy));

    // shared memory: registered read, bench write port, parser writes word 3
    always @(posedge clk) begin
        mem_rdata <= mem[mem_raddr[11:0]];
        if (tb_we)  mem[tb_addr] <= tb_data;
        if (mem_we) mem[3] <= mem_wdata;
    end

    task automatic chk(bit ok, string req, string what, logic [191:0] act, logic [191:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000 && !done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end

    // reference comparison on every clock
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_stall)
                chk(cmd_valid && cmd_args == prev_args && cmd_kind == prev_kind,
                    "R6", "stalled command held", cmd_args, prev_args);
            if (cmd_valid && ready) begin
                out_cnt++;
                if (exp_kind.size() == 0) begin
                    chk(0, "R7", "unexpected command", {190'd0, cmd_kind}, 192'd0);
                end else begin
                    chk(cmd_kind == 2'(exp_kind[0]), exp_req[0], "kind",
                        {190'd0, cmd_kind}, 192'(exp_kind[0]));
                    chk(cmd_args == exp_args[0], exp_req[0], "args", cmd_args, exp_args[0]);
                    void'(exp_kind.pop_front());
                    void'(exp_args.pop_front());
                    void'(exp_req.pop_front());
                end
            end
            if (unknown) unk_cnt++;
            prev_stall = cmd_valid && !ready;
            prev_args  = cmd_args;
            prev_kind  = cmd_kind;
        end
    end

    task automatic wr(int a, logic [31:0] d);
        tb_we = 1'b1; tb_addr = 12'(a); tb_data = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic push(logic [31:0] d);
        wr(wp >> 2, d);
        wp = (wp + 4 >= rmax) ? rmin : wp + 4;   // R10 wrap in the model
    endtask

    task automatic publish(); wr(2, wp); endtask

    task automatic set_hdr(int lo, int hi, int w, int r);
        wr(0, lo); wr(1, hi); wr(2, w); wr(3, r);
        rmin = lo; rmax = hi; wp = w;
    endtask

    task automatic do_commit();
        commit = 1'b1; @(negedge clk); commit = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic pulse_sync();
        sync = 1'b1; @(negedge clk); sync = 1'b0;
    endtask

    task automatic expect_cmd(int k, logic [191:0] a, string req);
        exp_kind.push_back(k); exp_args.push_back(a); exp_req.push_back(req);
    endtask

    task automatic send_update(int op, int x, int y, int w, int h);
        push(op); push(x); push(y); push(w); push(h);
        expect_cmd(0, {64'd0, 32'(h), 32'(w), 32'(y), 32'(x)}, "R3");
    endtask

    task automatic send_fill(int c, int x, int y, int w, int h, bit exp);
        push(2); push(c); push(x); push(y); push(w); push(h);
        if (exp) expect_cmd(1, {32'd0, 32'(h), 32'(w), 32'(y), 32'(x), 32'(c)}, "R4");
    endtask

    task automatic send_copy(int sx, int sy, int dx, int dy, int w, int h, string req);
        push(3); push(sx); push(sy); push(dx); push(dy); push(w); push(h);
        expect_cmd(2, {32'(h), 32'(w), 32'(dy), 32'(dx), 32'(sy), 32'(sx)}, req);
    endtask

    task automatic wait_drain(string req);
        int t = 0;
        while ((exp_kind.size() != 0 || mem[3] != 32'(wp)) && t < 3000) begin
            @(negedge clk); t++;
        end
        chk(exp_kind.size() == 0, req, "all expected commands seen",
            192'(exp_kind.size()), 192'd0);
        chk(mem[3] == 32'(wp), req, "read offset after drain", {160'd0, mem[3]}, 192'(wp));
    endtask

    initial begin
        int old_rd, old_out, u0;
        rst = 1'b1; enable = 1'b0; commit = 1'b0; sync = 1'b0; ready = 1'b1; tb_we = 1'b0;
        rmin = 16; rmax = 10256; wp = 16;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!cmd_valid && !busy && !configured && !unknown && !mem_we, "R1", "reset outputs",
            {187'd0, cmd_valid, busy, configured, unknown, mem_we}, 192'd0);

        enable = 1'b1;
        // R2 header validation, one fault at a time
        set_hdr(20, 20 + 10240, 22, 20); do_commit();
        chk(!configured, "R2", "misaligned offset rejected", {191'd0, configured}, 192'd0);
        set_hdr(12, 12 + 10240, 12, 12); do_commit();
        chk(!configured, "R2", "lower bound below 16 rejected", {191'd0, configured}, 192'd0);
        set_hdr(16, 32'h10004, 16, 16); do_commit();
        chk(!configured, "R2", "upper bound above limit rejected", {191'd0, configured}, 192'd0);
        set_hdr(16, 16 + 10236, 16, 16); do_commit();
        chk(!configured, "R2", "short span rejected", {191'd0, configured}, 192'd0);
        set_hdr(16, 32'h10000, 16, 16); do_commit();
        chk(configured, "R2", "upper bound at limit accepted", {191'd0, configured}, 192'd1);
        set_hdr(16, 10256, 16, 16); do_commit();
        chk(configured, "R2", "working header accepted", {191'd0, configured}, 192'd1);

        // R3 R4 R5 back-to-back drawing commands
        send_update(1, 10, 20, 30, 40);
        send_update(25, 5, 6, 7, 8);
        send_fill(32'hAABBCCDD, 1, 2, 3, 4, 1'b1);
        send_copy(11, 12, 13, 14, 15, 16, "R5");
        publish();
        wait_drain("R5");

        // R6 stall behind a low ready
        ready = 1'b0; old_rd = wp;
        send_fill(32'h123, 9, 8, 7, 6, 1'b1);
        publish();
        repeat (40) @(negedge clk);
        chk(cmd_valid, "R6", "command waits while ready low", {191'd0, cmd_valid}, 192'd1);
        chk(mem[3] == 32'(old_rd), "R6", "offset not written while stalled",
            {160'd0, mem[3]}, 192'(old_rd));
        ready = 1'b1;
        wait_drain("R6");

        // R7 partially published copy
        old_rd = wp; old_out = out_cnt;
        push(3); push(100); push(101);
        publish();
        repeat (60) @(negedge clk);
        chk(out_cnt == old_out, "R7", "no output for incomplete command",
            192'(out_cnt), 192'(old_out));
        chk(mem[3] == 32'(old_rd), "R7", "offset rewound to opcode",
            {160'd0, mem[3]}, 192'(old_rd));
        push(102); push(103); push(104); push(105);
        expect_cmd(2, {32'd105, 32'd104, 32'd103, 32'd102, 32'd101, 32'd100}, "R7");
        publish();
        wait_drain("R7");

        // R8 R9 skipped, no-op and unknown opcodes
        u0 = unk_cnt;
        push(13); for (int i = 0; i < 6;  i++) push(2);
        push(14); for (int i = 0; i < 7;  i++) push(3);
        push(28); for (int i = 0; i < 12; i++) push(1);
        push(0); push(26); push(27); push(29); push(30);
        push(99); push(19);
        send_update(1, 1, 1, 2, 2);
        publish();
        wait_drain("R8");
        chk(unk_cnt - u0 == 2, "R9", "unknown pulses", 192'(unk_cnt - u0), 192'd2);

        // R11 busy across a stalled command
        ready = 1'b0;
        send_fill(7, 7, 7, 7, 7, 1'b1);
        publish();
        repeat (30) @(negedge clk);
        pulse_sync();
        chk(busy, "R11", "busy after sync", {191'd0, busy}, 192'd1);
        repeat (30) @(negedge clk);
        chk(busy, "R11", "busy while command waits", {191'd0, busy}, 192'd1);
        ready = 1'b1;
        wait_drain("R11");
        repeat (20) @(negedge clk);
        chk(!busy, "R11", "busy clears once drained", {191'd0, busy}, 192'd0);
        pulse_sync();
        chk(busy, "R11", "busy after idle sync", {191'd0, busy}, 192'd1);
        repeat (20) @(negedge clk);
        chk(!busy, "R11", "idle sync clears", {191'd0, busy}, 192'd0);

        // R12 disabled device
        enable = 1'b0;
        repeat (3) @(negedge clk);
        chk(!configured, "R12", "disable clears configured", {191'd0, configured}, 192'd0);
        old_rd = mem[3]; old_out = out_cnt;
        send_fill(1, 2, 3, 4, 5, 1'b0);
        publish();
        repeat (40) @(negedge clk);
        chk(out_cnt == old_out && mem[3] == 32'(old_rd), "R12", "nothing parsed while disabled",
            {160'd0, mem[3]}, 192'(old_rd));
        pulse_sync();
        repeat (5) @(negedge clk);
        chk(!busy, "R12", "sync clears while disabled", {191'd0, busy}, 192'd0);

        // R10 copy straddling the upper bound
        set_hdr(16, 10256, 10248, 10248);
        enable = 1'b1;
        do_commit();
        chk(configured, "R10", "wrap header accepted", {191'd0, configured}, 192'd1);
        send_copy(21, 22, 23, 24, 25, 26, "R10");
        publish();
        wait_drain("R10");
        chk(mem[3] == 32'd36, "R10", "offset after wrap", {160'd0, mem[3]}, 192'd36);

        done = 1;
        summary();
        $finish;
    end
endmodule